// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block paces an external 8-bit analog-to-digital converter from a slow 32.768 kHz logic clock. It steps the converter through four inputs in a fixed rotation. For each conversion it drives a channel number, a one-cycle start pulse and a one-cycle capture strobe. The converter's output word is taken in on the capture strobe and written into a result slot for that channel. A fixed number of clocks after every capture, a comparator-update strobe reports which channel has fresh data. Downstream threshold logic uses this strobe to refresh its output.

Two run modes exist. In continuous mode, conversions follow each other with no gap. In interval mode, a burst starts at every wrap of a free-running interval counter. The period is 1 s or 4 s of clock time. Each burst is a settling gap followed by one pass over all four inputs. A shutdown request stops conversion and keeps the results. A reset request stops conversion and sets every result to all-ones. The asynchronous reset input does the same. Requests are acted on at a conversion boundary, so a conversion that has started always finishes.

The controller has four states:
- `ST_HALT`: stopped.
- `ST_SETTLE`: the settling gap before a burst.
- `ST_CONV`: a conversion is running.
- `ST_WAIT`: idle between bursts.

Its transitions are:
- HALT→CONV: released in continuous mode.
- HALT→SETTLE: released in interval mode.
- SETTLE→CONV: the gap has elapsed.
- CONV→CONV: next channel, or a new pass in continuous mode.
- CONV→WAIT: the pass has ended in interval mode.
- WAIT→SETTLE: the interval counter wraps.
- WAIT→CONV: interval mode has been cleared.
- Any state→HALT: a stop request, taken in CONV only on the last cycle of a conversion.

Top module: `adc_scan_sequencer`

## Requirements
- R1: While `rst_n` is low, every result slot reads FFh and `conv_start`, `conv_capture` and `cmp_update` are 0. On release with no stop request and interval mode off, `conv_start` rises for channel code 0 in the first cycle after the first rising edge.
- R2: Channel codes 0, 1, 2 and 3 (inputs one to four) are converted strictly in the order 0, 1, 2, 3, 0, and so on. Every pass starts at code 0.
- R3: A conversion lasts `CONV_CLKS` (10) cycles. `conv_start` is high only in its first cycle and `conv_capture` only in its last, and `chan_sel` is constant throughout.
- R4: On a capture cycle, `adc_data` is written into the slot of the channel being converted. The slot sits at bit offset 8 × code in `results` and shows the new value from the next cycle on. No other slot changes.
- R5: In continuous mode, a new conversion starts in the cycle after each capture. A full pass therefore takes 40 cycles.
- R6: In interval mode, bursts begin every `FAST_PERIOD` cycles (32768 by default) when `cfg_fast` is 1. They begin every `SLOW_PERIOD` cycles (131072 by default) when it is 0.
- R7: A burst is `SETTLE_CLKS` (20) idle cycles followed by four conversions, 60 cycles in all. It starts when the interval counter is zero. The counter is zero in the first cycle after leaving a stop.
- R8: `cmp_update` pulses exactly `CMP_DELAY` (10) cycles after each capture cycle. In that cycle, `cmp_chan` carries the code of the captured channel.
- R9: When `cfg_shutdown` is raised, a conversion in progress still completes with its capture. If no conversion is running, the block stops at once. While stopped there are no start or capture pulses and the results hold. Releasing the request restarts from code 0 with the interval counter cleared.
- R10: When `cfg_reset` is raised, the block stops at the same boundary as for shutdown. All result slots read FFh from the second cycle after the final capture cycle. The pending comparator update of that final capture is dropped.
- R11: When interval mode is selected during continuous running, the current pass finishes. No conversion follows until the next interval-counter wrap, and that wrap starts a normal burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz logic clock |
| rst_n | input | 1 | Asynchronous active-low reset and power-save |
| cfg_shutdown | input | 1 | Stop conversion, keep results |
| cfg_reset | input | 1 | Stop conversion, set results to FFh |
| cfg_interval | input | 1 | 1 = interval bursts, 0 = continuous |
| cfg_fast | input | 1 | Interval period select: 1 = short, 0 = long |
| adc_data | input | DW | Converter output, valid on the capture cycle |
| chan_sel | output | CH_W | Channel code being converted |
| conv_start | output | 1 | Start-of-conversion pulse |
| conv_capture | output | 1 | Result capture strobe |
| cmp_update | output | 1 | Delayed comparator-update strobe |
| cmp_chan | output | CH_W | Channel code paired with `cmp_update` |
| results | output | NCH*DW | Result slots, channel code c at bits [8c+7:8c] |

## Verification
A wrong phase or channel count shows at the ports within one conversion (ten cycles). It appears as a misplaced start or capture pulse, or as a channel code out of order. A wrong interval counter or settling count is only seen when the next burst begins. This is one short period in the reduced bench configuration, and the bench predicts every burst edge by arithmetic. Faults in the stop path show within about a dozen cycles of the request. The signs are an extra conversion, a lost final capture, results that change while stopped, or a comparator strobe that should have been dropped.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_CONV   = 2'd2,
        ST_WAIT   = 2'd3
    } scan_state_t;
endpackage

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
    import adc_scan_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int CH_W        = 2,
    parameter int CONV_CLKS   = 10,
    parameter int SETTLE_CLKS = 20,
    parameter int FAST_PERIOD = 32768,
    parameter int SLOW_PERIOD = 131072
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt_req,
    input  logic            ivl_mode,
    input  logic            fast_rate,
    output scan_state_t     state,
    output logic [CH_W-1:0] chan,
    output logic            start,
    output logic            capture
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PH_MAX = (CONV_CLKS > SETTLE_CLKS) ? CONV_CLKS : SETTLE_CLKS;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int CNT_W  = $clog2(SLOW_PERIOD + 1);
    localparam logic [PH_W-1:0] CONV_LAST   = PH_W'(CONV_CLKS - 1);
    localparam logic [PH_W-1:0] SETTLE_LAST = PH_W'(SETTLE_CLKS - 1);
    localparam logic [CH_W-1:0] CH_LAST     = CH_W'(NCH - 1);

    scan_state_t      state_n;
    logic [PH_W-1:0]  phase, phase_n;
    logic [CH_W-1:0]  chan_n;
    logic [CNT_W-1:0] ivl_cnt, ivl_cnt_n, period_last;

    assign period_last = fast_rate ? CNT_W'(FAST_PERIOD - 1) : CNT_W'(SLOW_PERIOD - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_HALT;
            phase   <= '0;
            chan    <= '0;
            ivl_cnt <= '0;
        end else begin
            state   <= state_n;
            phase   <= phase_n;
            chan    <= chan_n;
            ivl_cnt <= ivl_cnt_n;
        end
    end

    // transitions
    always_comb begin
        state_n   = state;
        phase_n   = phase;
        chan_n    = chan;
        ivl_cnt_n = ((state == ST_HALT) || (ivl_cnt >= period_last)) ? '0 : ivl_cnt + CNT_W'(1);
        unique case (state)
            ST_HALT: begin
                phase_n = '0;
                chan_n  = '0;
                if (!halt_req) state_n = ivl_mode ? ST_SETTLE : ST_CONV;
            end
            ST_SETTLE: begin
                if (halt_req) begin
                    state_n = ST_HALT;
                end else if (phase == SETTLE_LAST) begin
                    state_n = ST_CONV;
                    phase_n = '0;
                    chan_n  = '0;
                end else begin
                    phase_n = phase + PH_W'(1);
                end
            end
            ST_CONV: begin
                if (phase == CONV_LAST) begin
                    phase_n = '0;
                    if (halt_req) begin
                        state_n = ST_HALT;
                    end else if (chan == CH_LAST) begin
                        chan_n = '0;
                        if (ivl_mode) state_n = ST_WAIT;
                    end else begin
                        chan_n = chan + CH_W'(1);
                    end
                end else begin
                    phase_n = phase + PH_W'(1);
                end
            end
            ST_WAIT: begin
                phase_n = '0;
                chan_n  = '0;
                if (halt_req)                     state_n = ST_HALT;
                else if (!ivl_mode)               state_n = ST_CONV;
                else if (ivl_cnt >= period_last)  state_n = ST_SETTLE;
            end
            default: state_n = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        start   = (state == ST_CONV) && (phase == '0);
        capture = (state == ST_CONV) && (phase == CONV_LAST);
    end
endmodule

// File: rtl/adc_scan_results.sv
module adc_scan_results #(
    parameter int NCH  = 4,
    parameter int DW   = 8,
    parameter int CH_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [DW-1:0]     wr_data,
    output logic [NCH*DW-1:0] slots
);
    timeunit 1ns;
    timeprecision 1ps;

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic [DW-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 slot_q <= '1;
            else if (clear)                             slot_q <= '1;
            else if (wr_en && (wr_chan == CH_W'(g)))    slot_q <= wr_data;
        end
        assign slots[g*DW +: DW] = slot_q;
    end
endmodule

// File: rtl/adc_scan_delay.sv
module adc_scan_delay #(
    parameter int CH_W  = 2,
    parameter int DELAY = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            in_vld,
    input  logic [CH_W-1:0] in_chan,
    output logic            out_vld,
    output logic [CH_W-1:0] out_chan
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [DELAY-1:0] vld_q;
    logic [CH_W-1:0]  chn_q [DELAY];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     begin vld_q[0] <= 1'b0; chn_q[0] <= '0; end
        else if (clear) begin vld_q[0] <= 1'b0; chn_q[0] <= '0; end
        else            begin vld_q[0] <= in_vld; chn_q[0] <= in_chan; end
    end

    for (genvar g = 1; g < DELAY; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     begin vld_q[g] <= 1'b0; chn_q[g] <= '0; end
            else if (clear) begin vld_q[g] <= 1'b0; chn_q[g] <= '0; end
            else            begin vld_q[g] <= vld_q[g-1]; chn_q[g] <= chn_q[g-1]; end
        end
    end

    assign out_vld  = vld_q[DELAY-1];
    assign out_chan = chn_q[DELAY-1];
endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
    import adc_scan_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int DW          = 8,
    parameter int CONV_CLKS   = 10,
    parameter int SETTLE_CLKS = 20,
    parameter int CMP_DELAY   = 10,
    parameter int FAST_PERIOD = 32768,
    parameter int SLOW_PERIOD = 131072,
    localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_shutdown,
    input  logic              cfg_reset,
    input  logic              cfg_interval,
    input  logic              cfg_fast,
    input  logic [DW-1:0]     adc_data,
    output logic [CH_W-1:0]   chan_sel,
    output logic              conv_start,
    output logic              conv_capture,
    output logic              cmp_update,
    output logic [CH_W-1:0]   cmp_chan,
    output logic [NCH*DW-1:0] results
);
    timeunit 1ns;
    timeprecision 1ps;

    scan_state_t state;
    logic        halt_req;
    logic        wipe;

    assign halt_req = cfg_shutdown | cfg_reset;
    assign wipe     = (state == ST_HALT) && cfg_reset;

    adc_scan_fsm #(
        .NCH(NCH), .CH_W(CH_W), .CONV_CLKS(CONV_CLKS), .SETTLE_CLKS(SETTLE_CLKS),
        .FAST_PERIOD(FAST_PERIOD), .SLOW_PERIOD(SLOW_PERIOD)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .ivl_mode(cfg_interval),
        .fast_rate(cfg_fast), .state(state), .chan(chan_sel),
        .start(conv_start), .capture(conv_capture)
    );

    adc_scan_results #(.NCH(NCH), .DW(DW), .CH_W(CH_W)) u_res (
        .clk(clk), .rst_n(rst_n), .clear(wipe), .wr_en(conv_capture),
        .wr_chan(chan_sel), .wr_data(adc_data), .slots(results)
    );

    adc_scan_delay #(.CH_W(CH_W), .DELAY(CMP_DELAY)) u_dly (
        .clk(clk), .rst_n(rst_n), .clear(wipe), .in_vld(conv_capture),
        .in_chan(chan_sel), .out_vld(cmp_update), .out_chan(cmp_chan)
    );
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk
    import adc_scan_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int DW        = 8,
    parameter int CH_W      = 2,
    parameter int CONV_CLKS = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_reset,
    input scan_state_t       state,
    input logic              conv_start,
    input logic              conv_capture,
    input logic [CH_W-1:0]   chan_sel,
    input logic [DW-1:0]     adc_data,
    input logic [NCH*DW-1:0] results
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SW = $clog2(CONV_CLKS + 1);

    logic [SW-1:0]   since_q;
    logic            cap_q;
    logic [CH_W-1:0] chan_q;
    logic [DW-1:0]   data_q;
    logic [DW-1:0]   slot_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            cap_q   <= 1'b0;
            chan_q  <= '0;
            data_q  <= '0;
        end else begin
            if (conv_start)                    since_q <= SW'(1);
            else if (since_q != SW'(CONV_CLKS)) since_q <= since_q + SW'(1);
            cap_q  <= conv_capture;
            chan_q <= chan_sel;
            data_q <= adc_data;
        end
    end

    assign slot_sel = results[chan_q*DW +: DW];

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R3
    AST_CAPTURE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        conv_capture |-> (since_q == SW'(CONV_CLKS - 1))); // R3
    AST_ROUND_ROBIN: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && $past(conv_capture)) |->
            (chan_sel == CH_W'((int'($past(chan_sel)) + 1) % NCH))); // R2
    AST_CAPTURE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q |-> (slot_sel == data_q)); // R4
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> (!conv_start && !conv_capture)); // R9
    AST_SHUTDOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HALT) && !cfg_reset) |=> $stable(results)); // R9
    AST_RESET_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HALT) && cfg_reset) |=> (results == '1)); // R10
endmodule

bind adc_scan_sequencer adc_scan_chk #(
    .NCH(NCH), .DW(DW), .CH_W(CH_W), .CONV_CLKS(CONV_CLKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_reset(cfg_reset), .state(state),
    .conv_start(conv_start), .conv_capture(conv_capture), .chan_sel(chan_sel),
    .adc_data(adc_data), .results(results)
);

// File: tb/adc_scan_sequencer_bench.sv
module adc_scan_sequencer_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int CV  = 10;
    localparam int ST  = 20;
    localparam int DL  = 10;
    localparam int FP  = 100;
    localparam int SP  = 250;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_shutdown, cfg_reset, cfg_interval, cfg_fast;
    logic [DW-1:0]     adc_data;
    logic [1:0]        chan_sel, cmp_chan;
    logic              conv_start, conv_capture, cmp_update;
    logic [NCH*DW-1:0] results;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] model [NCH];
    int hist [1024];

    always #2.5 clk = ~clk;

    adc_scan_sequencer #(
        .NCH(NCH), .DW(DW), .CONV_CLKS(CV), .SETTLE_CLKS(ST), .CMP_DELAY(DL),
        .FAST_PERIOD(FP), .SLOW_PERIOD(SP)
    ) u_adc_scan_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_shutdown(cfg_shutdown), .cfg_reset(cfg_reset),
        .cfg_interval(cfg_interval), .cfg_fast(cfg_fast), .adc_data(adc_data),
        .chan_sel(chan_sel), .conv_start(conv_start), .conv_capture(conv_capture),
        .cmp_update(cmp_update), .cmp_chan(cmp_chan), .results(results)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_reset_state(input string tag);
        for (int c = 0; c < NCH; c++) chk({tag, " slot"}, int'(results[c*DW +: DW]), 255);
        chk({tag, " start"}, int'(conv_start), 0);
        chk({tag, " capture"}, int'(conv_capture), 0);
        chk({tag, " cmp_update"}, int'(cmp_update), 0);
    endtask

    // Runs one window from release of all stop requests; caller is at a falling edge.
    task automatic run_seq(input string lbl, input bit ivl, input bit fast, input int ncyc,
                           input int halt_at, input bit halt_rst, input int sw_at);
        int per, cont_until, ivl_from, stop;
        per = fast ? FP : SP;
        if (sw_at >= 0) begin
            cont_until = sw_at + (NCH*CV - 1 - sw_at % (NCH*CV));
            ivl_from   = cont_until + 2;
        end else if (ivl) begin
            cont_until = -1;
            ivl_from   = 0;
        end else begin
            cont_until = 1 << 30;
            ivl_from   = 1 << 30;
        end
        stop = -1;
        for (int i = 0; i < 1024; i++) hist[i] = -1;
        rst_n = 1'b1; cfg_interval = ivl; cfg_fast = fast;
        cfg_shutdown = 1'b0; cfg_reset = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            bit inconv, soc, cap, ecmp;
            int ch, ph, p;
            @(negedge clk);
            inconv = 1'b0; ch = 0; ph = 0;
            if (stop < 0 || k <= stop) begin
                if (k <= cont_until) begin
                    inconv = 1'b1; ph = k % CV; ch = (k / CV) % NCH;
                end else begin
                    p = k % per;
                    if ((k - p) >= ivl_from && p >= ST && p < ST + NCH*CV) begin
                        inconv = 1'b1; ph = (p - ST) % CV; ch = (p - ST) / CV;
                    end
                end
            end
            soc = inconv && (ph == 0);
            cap = inconv && (ph == CV - 1);
            chk({lbl, " R3 start"}, int'(conv_start), int'(soc));
            chk({lbl, " R3 capture"}, int'(conv_capture), int'(cap));
            if (soc || cap) chk({lbl, " R2 channel"}, int'(chan_sel), ch);
            ecmp = (k >= DL) && (hist[k-DL] >= 0);
            chk({lbl, " R8 cmp_update"}, int'(cmp_update), int'(ecmp));
            if (ecmp) chk({lbl, " R8 cmp_chan"}, int'(cmp_chan), hist[k-DL]);
            for (int c = 0; c < NCH; c++)
                chk({lbl, " R4 result"}, int'(results[c*DW +: DW]), int'(model[c]));
            adc_data = DW'(k * 37 + 11 + ncyc);
            if (cap) begin model[ch] = adc_data; hist[k] = ch; end
            if (stop >= 0 && k > stop && halt_rst)
                for (int c = 0; c < NCH; c++) model[c] = '1;
            if (k == sw_at) cfg_interval = 1'b1;
            if (k == halt_at) begin
                if (halt_rst) cfg_reset = 1'b1; else cfg_shutdown = 1'b1;
            end
            if (halt_at >= 0 && k >= halt_at && stop < 0 && (!inconv || cap)) begin
                stop = k;
                if (halt_rst) hist[k] = -1;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_shutdown = 1'b0; cfg_reset = 1'b0;
        cfg_interval = 1'b0; cfg_fast = 1'b0; adc_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_reset_state("R1 reset");
        for (int c = 0; c < NCH; c++) model[c] = '1;
        // continuous from reset, shutdown mid-conversion
        run_seq("R1 R5 R9", 1'b0, 1'b0, 140, 103, 1'b0, -1);
        // restart keeps held results, reset request mid-conversion
        run_seq("R5 R9 R10", 1'b0, 1'b0, 80, 57, 1'b1, -1);
        // short interval, shutdown during settling gap
        run_seq("R6 R7 R9", 1'b1, 1'b1, 330, 305, 1'b0, -1);
        // long interval, reset during a burst conversion
        run_seq("R6 R7 R10", 1'b1, 1'b0, 560, 530, 1'b1, -1);
        // continuous switched to interval mid-pass
        run_seq("R11 R9", 1'b0, 1'b1, 275, 240, 1'b0, 55);
        rst_n = 1'b0;
        #1;
        chk_reset_state("R1 async reset");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule